// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between an on-chip request bus and an external asynchronous static RAM of 32768 bytes. It takes one read or write request at a time through a valid/ready handshake. It then drives the memory's address, its active-low chip, output and write enables, and a bidirectional byte bus split into output, output-enable and input. Read data is captured into a register on the system clock and returned with a single-cycle valid pulse.

All memory-side signals come straight from flops. Each read access and each write pulse lasts a whole number of system clocks. Those counts are derived from parameters: the clock period and the memory's minimum access, write-pulse, write-cycle and output-release times, each rounded up. When a write comes after a read, the controller keeps its data drivers off for extra cycles. This gives the memory time to release the data pins.

Top module: `asram_ctrl`

## Requirements
- R1: During and after reset, and whenever the controller is idle, the memory pins are in standby: chip, output and write enables are all high (1), the data output enable is 0, `req_ready` is 1 and `rsp_valid` is 0.
- R2: An accepted read (`req_write`=0) drives chip enable 0, output enable 0, write enable 1 and data output enable 0 for exactly RD_CYC = max(1, ceil(T_ACCESS_NS/CLK_NS)) cycles, starting the cycle after acceptance. The address stays constant throughout.
- R3: The byte on `mem_dq_in` in the last read-access cycle is registered onto `rsp_rdata`. `rsp_valid` is 1 for exactly one cycle, the cycle after that access, and `rsp_rdata` holds its value until the next read completes.
- R4: An accepted write (`req_write`=1) drives chip enable 0, write enable 0, output enable 1, data output enable 1, the request address and the request data for exactly WR_CYC cycles. WR_CYC = max(1, ceil(T_WPULSE_NS/CLK_NS), ceil(T_WCYCLE_NS/CLK_NS)-1).
- R5: After the write pulse comes exactly one cycle with write enable 1, chip enable 0 and the data still driven unchanged. After that cycle the pins return to standby.
- R6: If the last completed operation was a read, a write spends TURN_CYC = max(1, ceil(T_RELEASE_NS/CLK_NS)) cycles in standby after acceptance, with data output enable 0, before its write pulse. Otherwise the write pulse starts the cycle after acceptance.
- R7: `req_ready` is 1 only while idle, so at most one transaction is in flight. It is 0 on every cycle of an access, turnaround, pulse or hold.
- R8: A write never raises `rsp_valid`.
- R9: Write enable and output enable are never both 0. The data output enable is never 1 while output enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Registered read data |
| mem_addr | output | ADDR_W | Memory address pins |
| mem_dq_in | input | DATA_W | Data pins as seen from the memory |
| mem_dq_out | output | DATA_W | Data to drive onto the pins |
| mem_dq_oe | output | 1 | Enable for the data pin drivers |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |

## Verification
A sequencer state that is wrong, or a cycle counter that is off by one, shows up at once at the pins. The enable pattern then lasts one cycle too long or too short, or the bus turnaround is missing. The bench compares the pins against the expected pattern on every cycle of each transaction. A corrupted capture or address path shows up at the latest on the next read of that address, because the bench writes every location of a reduced address space and reads it back.

// File: rtl/asram_pkg.sv
// Shared types for the asynchronous SRAM controller.
// Assumes: control pins are active low; driver enable is active high.
package asram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_ACC,
        ST_TURN,
        ST_WR_PULSE,
        ST_WR_HOLD
    } seq_state_t;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drv;
    } pin_ctl_t;

    localparam pin_ctl_t CTL_STANDBY = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drv: 1'b0};
    localparam pin_ctl_t CTL_READ    = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drv: 1'b0};
    localparam pin_ctl_t CTL_WPULSE  = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drv: 1'b1};
    localparam pin_ctl_t CTL_WHOLD   = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b1, drv: 1'b1};

    // Round a nanosecond requirement up to whole clocks.
    function automatic int clocks_for(int ns, int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int max2(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Pin pattern that belongs to a sequencer state.
    function automatic pin_ctl_t ctl_of(seq_state_t s);
        case (s)
            ST_RD_ACC:   return CTL_READ;
            ST_WR_PULSE: return CTL_WPULSE;
            ST_WR_HOLD:  return CTL_WHOLD;
            default:     return CTL_STANDBY;
        endcase
    endfunction

endpackage

// File: rtl/asram_cnt.sv
// Down-counter that measures the length of a sequencer phase.
// Assumes: load has priority; the counter stops at zero.
module asram_cnt #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);

    logic [W-1:0] cnt;

    // Load a phase length or count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

endmodule

// File: rtl/asram_seq.sv
// Transaction sequencer: accepts one request at a time and steps through
// read access, turnaround, write pulse and write hold phases.
// Assumes: every phase length is at least one clock.
module asram_seq
    import asram_pkg::*;
#(
    parameter int RD_CYC   = 1,
    parameter int WR_CYC   = 1,
    parameter int TURN_CYC = 1
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     req_valid,
    input  logic     req_write,
    output logic     req_ready,
    output logic     accept,
    output logic     capture,
    output pin_ctl_t ctl_next
);

    localparam int MAXC = max2(max2(RD_CYC, WR_CYC), TURN_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RD_LD   = CW'(RD_CYC - 1);
    localparam logic [CW-1:0] WR_LD   = CW'(WR_CYC - 1);
    localparam logic [CW-1:0] TURN_LD = CW'(TURN_CYC - 1);

    seq_state_t    state, state_nxt;
    logic          last_rd;
    logic          ld;
    logic [CW-1:0] ld_val;
    logic          cnt_zero;

    asram_cnt #(.W(CW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .zero     (cnt_zero)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;

    // Next-state decision and phase-length loading.
    always_comb begin
        state_nxt = state;
        ld        = 1'b0;
        ld_val    = '0;
        capture   = 1'b0;
        case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    ld = 1'b1;
                    if (!req_write) begin
                        state_nxt = ST_RD_ACC;
                        ld_val    = RD_LD;
                    end else if (last_rd) begin
                        state_nxt = ST_TURN;
                        ld_val    = TURN_LD;
                    end else begin
                        state_nxt = ST_WR_PULSE;
                        ld_val    = WR_LD;
                    end
                end
            end
            ST_RD_ACC: begin
                if (cnt_zero) begin
                    state_nxt = ST_IDLE;
                    capture   = 1'b1;
                end
            end
            ST_TURN: begin
                if (cnt_zero) begin
                    state_nxt = ST_WR_PULSE;
                    ld        = 1'b1;
                    ld_val    = WR_LD;
                end
            end
            ST_WR_PULSE: begin
                if (cnt_zero)
                    state_nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: state_nxt = ST_IDLE;
            default:    state_nxt = ST_IDLE;
        endcase
    end

    assign ctl_next = ctl_of(state_nxt);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nxt;
    end

    // Remember whether the memory drove the bus last, for the turnaround.
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_rd <= 1'b0;
        else if (capture)
            last_rd <= 1'b1;
        else if (state_nxt == ST_WR_PULSE)
            last_rd <= 1'b0;
    end

    AST_TURN_BEFORE_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && accept && req_write && last_rd) |=> (state == ST_TURN)); // R6

endmodule

// File: rtl/asram_pins.sv
// Pin register stage: every memory-side output comes from a flop.
// Assumes: the address and write data are loaded only when a request is accepted.
module asram_pins
    import asram_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  pin_ctl_t          ctl_next,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] data_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    pin_ctl_t ctl_q;

    // Control pins: standby in reset, otherwise the sequencer's next pattern.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctl_q <= CTL_STANDBY;
        else
            ctl_q <= ctl_next;
    end

    // Address and data are captured once per accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
        end else if (load) begin
            mem_addr   <= addr_in;
            mem_dq_out <= data_in;
        end
    end

    assign mem_ce_n  = ctl_q.ce_n;
    assign mem_oe_n  = ctl_q.oe_n;
    assign mem_we_n  = ctl_q.we_n;
    assign mem_dq_oe = ctl_q.drv;

    AST_NO_WE_OE_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_we_n && !mem_oe_n)); // R9
    AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n); // R9
    AST_WPULSE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (mem_dq_oe && !mem_ce_n)); // R4
    AST_HOLD_AFTER_WE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we_n) |-> (mem_dq_oe && !mem_ce_n && $stable(mem_dq_out))); // R5
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr)); // R2
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_dq_oe) |-> ($past(mem_oe_n, 1) && $past(mem_oe_n, 2))); // R6

endmodule

// File: rtl/asram_ctrl.sv
// Asynchronous SRAM controller top: valid/ready request side, registered
// read response, flop-driven memory pins.
// Assumes: one request in flight; mem_dq_in is the resolved pin value.
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int CLK_NS      = 10,
    parameter int T_ACCESS_NS = 10,
    parameter int T_WPULSE_NS = 8,
    parameter int T_WCYCLE_NS = 10,
    parameter int T_RELEASE_NS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_oe,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n
);

    localparam int RD_CYC   = max2(1, clocks_for(T_ACCESS_NS, CLK_NS));
    localparam int WR_CYC   = max2(max2(1, clocks_for(T_WPULSE_NS, CLK_NS)),
                                   clocks_for(T_WCYCLE_NS, CLK_NS) - 1);
    localparam int TURN_CYC = max2(1, clocks_for(T_RELEASE_NS, CLK_NS));

    logic     accept;
    logic     capture;
    pin_ctl_t ctl_next;

    asram_seq #(
        .RD_CYC   (RD_CYC),
        .WR_CYC   (WR_CYC),
        .TURN_CYC (TURN_CYC)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_ready (req_ready),
        .accept    (accept),
        .capture   (capture),
        .ctl_next  (ctl_next)
    );

    asram_pins #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctl_next   (ctl_next),
        .load       (accept),
        .addr_in    (req_addr),
        .data_in    (req_wdata),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_ce_n   (mem_ce_n),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n)
    );

    // Register read data at the end of the access; pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= capture;
            if (capture)
                rsp_rdata <= mem_dq_in;
        end
    end

    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R3
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!mem_oe_n) && $past(mem_we_n))); // R8
    AST_READY_IS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (mem_ce_n && !mem_dq_oe)); // R7

endmodule

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;

    localparam int CLK_PERIOD = 4;
    localparam int AW = 6;
    localparam int DW = 8;
    localparam int DEPTH = 1 << AW;

    function automatic int up(int ns);
        return (ns + CLK_PERIOD - 1) / CLK_PERIOD;
    endfunction
    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    localparam int RD_E   = mx(1, up(10));
    localparam int WR_E   = mx(mx(1, up(8)), up(10) - 1);
    localparam int TURN_E = mx(1, up(5));

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          rsp_valid;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_dq_in;
    logic [DW-1:0] mem_dq_out;
    logic          mem_dq_oe, mem_ce_n, mem_oe_n, mem_we_n;

    logic [DW-1:0] mem    [DEPTH];
    logic [DW-1:0] shadow [DEPTH];
    int  n_chk = 0;
    int  n_bad = 0;
    bit  last_rd = 1'b0;
    bit  done = 1'b0;

    always #(CLK_PERIOD/2.0) clk = ~clk;

    asram_ctrl #(
        .ADDR_W (AW), .DATA_W (DW), .CLK_NS (CLK_PERIOD),
        .T_ACCESS_NS (10), .T_WPULSE_NS (8), .T_WCYCLE_NS (10), .T_RELEASE_NS (5)
    ) u_asram_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .mem_addr (mem_addr), .mem_dq_in (mem_dq_in), .mem_dq_out (mem_dq_out),
        .mem_dq_oe (mem_dq_oe), .mem_ce_n (mem_ce_n), .mem_oe_n (mem_oe_n),
        .mem_we_n (mem_we_n)
    );

    // Memory model: drives only in read mode, stores on the rising write enable.
    assign mem_dq_in = (!mem_ce_n && !mem_oe_n && mem_we_n) ? mem[mem_addr] : 8'hEE;
    always @(posedge mem_we_n)
        if (!mem_ce_n && mem_dq_oe) mem[mem_addr] <= mem_dq_out;

    task automatic chk(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] pins();
        return {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe};
    endfunction

    // Bus contention watch on every cycle.
    always @(negedge clk)
        if (rst_n && !done)
            chk(!(mem_dq_oe && !mem_oe_n) && !(!mem_we_n && !mem_oe_n), "R9",
                "drive or write during output enable", int'(pins()), 0);

    task automatic do_read(int a);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < RD_E; i++) begin
            chk(pins() == 4'b0010 && mem_addr == AW'(a), "R2", "read pins/addr",
                int'({pins(), 2'b00, mem_addr}), int'({4'b0010, 2'b00, AW'(a)}));
            chk(!req_ready, "R7", "ready during access", int'(req_ready), 0);
            @(negedge clk);
        end
        chk(rsp_valid && rsp_rdata == shadow[a], "R3", "read data",
            int'({rsp_valid, rsp_rdata}), int'({1'b1, shadow[a]}));
        chk(pins() == 4'b1110 && req_ready, "R1", "standby after read",
            int'({pins(), req_ready}), int'({4'b1110, 1'b1}));
        @(negedge clk);
        chk(!rsp_valid && rsp_rdata == shadow[a], "R3", "pulse length / hold",
            int'({rsp_valid, rsp_rdata}), int'({1'b0, shadow[a]}));
        last_rd = 1'b1;
    endtask

    task automatic do_write(int a, logic [DW-1:0] d);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0;
        if (last_rd) begin
            for (int i = 0; i < TURN_E; i++) begin
                chk(pins() == 4'b1110 && !req_ready, "R6", "turnaround idle",
                    int'({pins(), req_ready}), int'({4'b1110, 1'b0}));
                @(negedge clk);
            end
        end
        for (int i = 0; i < WR_E; i++) begin
            chk(pins() == 4'b0101 && mem_addr == AW'(a) && mem_dq_out == d, "R4",
                "write pulse", int'({pins(), mem_dq_out}), int'({4'b0101, d}));
            chk(!req_ready, "R7", "ready during write", int'(req_ready), 0);
            @(negedge clk);
        end
        chk(pins() == 4'b0111 && mem_dq_out == d, "R5", "write hold",
            int'({pins(), mem_dq_out}), int'({4'b0111, d}));
        @(negedge clk);
        chk(pins() == 4'b1110 && req_ready, "R5", "standby after hold",
            int'({pins(), req_ready}), int'({4'b1110, 1'b1}));
        chk(!rsp_valid, "R8", "no response for write", int'(rsp_valid), 0);
        shadow[a] = d;
        last_rd = 1'b0;
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin
            mem[i] = DW'(i * 7 + 3);
            shadow[i] = DW'(i * 7 + 3);
        end
        repeat (3) @(negedge clk);
        chk(pins() == 4'b1110 && req_ready && !rsp_valid, "R1", "reset state",
            int'({pins(), req_ready, rsp_valid}), int'({4'b1110, 2'b10}));
        rst_n = 1'b1;
        @(negedge clk);
        chk(pins() == 4'b1110 && req_ready && !rsp_valid, "R1", "idle after reset",
            int'({pins(), req_ready, rsp_valid}), int'({4'b1110, 2'b10}));
        // Initial contents, then a full write sweep (first write has the turnaround).
        for (int a = 0; a < DEPTH; a++) do_read(a);
        for (int a = 0; a < DEPTH; a++) do_write(a, DW'((a * 13 + 5) ^ 8'hA5));
        for (int a = 0; a < DEPTH; a++) do_read(a);
        // Alternating write/read: every write follows a read.
        for (int a = 0; a < DEPTH; a++) begin
            do_write(DEPTH - 1 - a, DW'(a * 29 + 1));
            do_read(DEPTH - 1 - a);
        end
        // Data corners at address corners.
        do_write(0, 8'h00);
        do_write(DEPTH - 1, 8'hFF);
        do_read(0);
        do_read(DEPTH - 1);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule